// File: doc/BRIEF.md
# Ping-Pong Sample Bank Row Scheduler

This block sequences the per-row control of a column readout that stores pixel values on sample-and-hold banks. There are two banks, and each has a reset-level capacitor and a signal-level capacitor for double sampling. A row load strobes the reset sample first and the signal sample second into one bank. A readout phase then drains that bank. In zero-overhead mode the loads and reads run on alternating banks, so the next row is captured while the previous row is read. This hides the row-operation time behind the readout. In classic mode only one bank is used, and load and read strictly take turns.

A frame is started with a pulse that latches the row total, the mode and the three phase lengths. A request for a global shutter operation is latched. It stops new phases from starting, and it is granted once both the load and read engines sit idle at a row boundary. While the grant is held, no strobe and no readout are active. Activity resumes when the done signal returns. Each phase length is a programmable cycle count, and a value of zero is treated as one.

Top module: `pprs_row_sched`

## Requirements
- R1: `frame_start` is accepted only when no frame is running and no global operation is pending or granted. An accepted start latches mode, row total and phase lengths, and raises `frame_busy` in the next cycle. A start at any other time has no effect. After reset all outputs are low.
- R2: Every row load drives `samp_rst` for max(1,`rst_cycles`) cycles, followed at once by `samp_sig` for max(1,`sig_cycles`) cycles. `load_bank` names the target bank (0 or 1) during both strobes.
- R3: Every row read drives `read_en` for max(1,`read_cycles`) consecutive cycles, with `read_bank` naming the bank being read.
- R4: In zero-overhead mode (`zero_ovh_mode`=1), row i is loaded into and read from bank i mod 2. A load of one bank may run during the read of the other. With L = rst+sig length and D = read length, the row period is max(L,D)+1 cycles.
- R5: In classic mode (`zero_ovh_mode`=0), only bank 0 is used and loading never overlaps reading. The row period is L+D+2 cycles.
- R6: A bank is never read while it is being loaded, and a row's readout starts only after its load has finished. The first load starts in the second cycle after the accepted start. Each readout starts one idle cycle after its bank's signal phase ends.
- R7: A `gop_req` pulse is latched, and no load or read phase starts while it is pending. `gop_grant` rises once both engines are idle and stays high, with all strobes and `read_en` low, until `gop_done`. It falls in the cycle after `gop_done`, and the frame then continues with every row completed.
- R8: `frame_done` is a one-cycle pulse in the cycle after the last `read_en` cycle of the frame, and `frame_busy` is low with it. With a row total of zero, `frame_done` pulses in the first cycle after the start and no strobe appears.
- R9: `gop_done` has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame start pulse |
| zero_ovh_mode | input | 1 | 1 = two-bank overlapped, 0 = classic single bank |
| row_total | input | ROW_W (13) | Rows in the frame |
| rst_cycles | input | CNT_W (10) | Reset-sample strobe length |
| sig_cycles | input | CNT_W (10) | Signal-sample strobe length |
| read_cycles | input | CNT_W (10) | Readout length per row |
| gop_req | input | 1 | Global shutter operation request |
| gop_done | input | 1 | Global shutter operation finished |
| samp_rst | output | 1 | Sample reset level into load bank |
| samp_sig | output | 1 | Sample signal level into load bank |
| load_bank | output | 1 | Bank targeted by the current load |
| read_bank | output | 1 | Bank being read |
| read_en | output | 1 | Readout enable |
| gop_grant | output | 1 | Global operation may proceed |
| frame_busy | output | 1 | Frame in progress |
| frame_done | output | 1 | Frame finished pulse |

## Verification
The bench builds the block with ROW_W=6 and CNT_W=4. With these values, phase lengths from the zero clamp up to the 15-cycle maximum and whole frames of up to a few rows take only tens of cycles each. Cases where the load outlasts the read, where the read outlasts the load, and where the two are equal can all be run in one short run. Under these settings, exact frame durations, the strobe totals per bank, a grant in the middle of a frame and a zero-row frame can each be predicted in closed form.

// File: rtl/pprs_pkg.sv
package pprs_pkg;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_RST  = 2'd1,
        LD_SIG  = 2'd2
    } ld_phase_e;

    localparam int unsigned BANKS = 2;

endpackage

// File: rtl/pprs_load_engine.sv
module pprs_load_engine
    import pprs_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_bank,
    input  logic [CNT_W-1:0] rst_len,
    input  logic [CNT_W-1:0] sig_len,
    output logic             samp_rst,
    output logic             samp_sig,
    output logic             bank,
    output logic             active,
    output logic             finish
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        ld_phase_e        phase;
        logic [CNT_W-1:0] cnt;
        logic             bank;
    } ld_state_t;

    ld_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        finish = 1'b0;
        unique case (s_q.phase)
            LD_IDLE: begin
                if (start) begin
                    s_d.phase = LD_RST;
                    s_d.cnt   = '0;
                    s_d.bank  = start_bank;
                end
            end
            LD_RST: begin
                if (s_q.cnt == rst_len - CNT_ONE) begin
                    s_d.phase = LD_SIG;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_ONE;
                end
            end
            LD_SIG: begin
                if (s_q.cnt == sig_len - CNT_ONE) begin
                    s_d.phase = LD_IDLE;
                    s_d.cnt   = '0;
                    finish    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_ONE;
                end
            end
            default: s_d.phase = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: LD_IDLE, cnt: '0, bank: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign samp_rst = (s_q.phase == LD_RST);
    assign samp_sig = (s_q.phase == LD_SIG);
    assign bank     = s_q.bank;
    assign active   = (s_q.phase != LD_IDLE);

    // R2: the signal strobe only ever follows a reset strobe directly
    assert_sig_after_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_sig) |-> $past(samp_rst));

    // R2: a reset strobe always hands over to the signal strobe
    assert_rst_to_sig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(samp_rst) |-> samp_sig);

    // R2: the target bank stays fixed for a whole load
    assert_bank_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(bank));

endmodule

// File: rtl/pprs_read_engine.sv
module pprs_read_engine #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_bank,
    input  logic [CNT_W-1:0] read_len,
    output logic             read_en,
    output logic             bank,
    output logic             finish
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             bank;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        finish = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.bank = start_bank;
            end
        end else if (s_q.cnt == read_len - CNT_ONE) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
            finish   = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, cnt: '0, bank: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign read_en = s_q.busy;
    assign bank    = s_q.bank;

    // R3: the bank under readout does not change mid-read
    assert_read_bank_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (read_en && $past(read_en)) |-> $stable(bank));

endmodule

// File: rtl/pprs_row_sched.sv
module pprs_row_sched
    import pprs_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             zero_ovh_mode,
    input  logic [ROW_W-1:0] row_total,
    input  logic [CNT_W-1:0] rst_cycles,
    input  logic [CNT_W-1:0] sig_cycles,
    input  logic [CNT_W-1:0] read_cycles,
    input  logic             gop_req,
    input  logic             gop_done,
    output logic             samp_rst,
    output logic             samp_sig,
    output logic             load_bank,
    output logic             read_bank,
    output logic             read_en,
    output logic             gop_grant,
    output logic             frame_busy,
    output logic             frame_done
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

    typedef struct packed {
        logic             busy;
        logic             zmode;
        logic [ROW_W-1:0] rows;
        logic [CNT_W-1:0] tr;
        logic [CNT_W-1:0] ts;
        logic [CNT_W-1:0] trd;
        logic [ROW_W-1:0] rows_ld;
        logic [ROW_W-1:0] rows_rd;
        logic [BANKS-1:0] full;
        logic             pend;
        logic             grant;
        logic             done;
    } sched_state_t;

    sched_state_t s_d, s_q;

    logic             ld_active, ld_finish, ld_bank;
    logic             rd_finish, rd_bank, rd_active;
    logic             ld_go, rd_go, hold;
    logic             ld_tgt, rd_tgt;
    logic [CNT_W-1:0] len_rst, len_sig, len_rd;
    logic [ROW_W-1:0] rd_count_next;

    // Phase lengths of zero are stretched to one cycle
    assign len_rst = (s_q.tr  == '0) ? CNT_ONE : s_q.tr;
    assign len_sig = (s_q.ts  == '0) ? CNT_ONE : s_q.ts;
    assign len_rd  = (s_q.trd == '0) ? CNT_ONE : s_q.trd;

    assign hold   = s_q.pend | s_q.grant;
    assign ld_tgt = s_q.zmode & s_q.rows_ld[0];
    assign rd_tgt = s_q.zmode & s_q.rows_rd[0];

    assign rd_count_next = s_q.rows_rd + ROW_ONE;

    assign ld_go = s_q.busy && !hold && !ld_active &&
                   (s_q.rows_ld != s_q.rows) && !s_q.full[ld_tgt];
    assign rd_go = s_q.busy && !hold && !rd_active &&
                   (s_q.rows_rd != s_q.rows) && s_q.full[rd_tgt];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;

        // Bank occupancy bookkeeping driven by engine completions
        if (ld_finish) begin
            s_d.full[ld_bank] = 1'b1;
            s_d.rows_ld       = s_q.rows_ld + ROW_ONE;
        end
        if (rd_finish) begin
            s_d.full[rd_bank] = 1'b0;
            s_d.rows_rd       = rd_count_next;
            if (rd_count_next == s_q.rows) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end

        // Frame acceptance
        if (!s_q.busy && !hold && frame_start) begin
            s_d.zmode   = zero_ovh_mode;
            s_d.rows    = row_total;
            s_d.tr      = rst_cycles;
            s_d.ts      = sig_cycles;
            s_d.trd     = read_cycles;
            s_d.rows_ld = '0;
            s_d.rows_rd = '0;
            s_d.full    = '0;
            if (row_total == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
            end
        end

        // Global operation arbitration at the row boundary
        if (s_q.grant) begin
            if (gop_done) begin
                s_d.grant = 1'b0;
            end
        end else if (s_q.pend) begin
            if (!ld_active && !rd_active) begin
                s_d.pend  = 1'b0;
                s_d.grant = 1'b1;
            end
        end else if (gop_req) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    pprs_load_engine #(
        .CNT_W (CNT_W)
    ) load_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ld_go),
        .start_bank (ld_tgt),
        .rst_len    (len_rst),
        .sig_len    (len_sig),
        .samp_rst   (samp_rst),
        .samp_sig   (samp_sig),
        .bank       (ld_bank),
        .active     (ld_active),
        .finish     (ld_finish)
    );

    pprs_read_engine #(
        .CNT_W (CNT_W)
    ) read_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rd_go),
        .start_bank (rd_tgt),
        .read_len   (len_rd),
        .read_en    (rd_active),
        .bank       (rd_bank),
        .finish     (rd_finish)
    );

    assign load_bank  = ld_bank;
    assign read_bank  = rd_bank;
    assign read_en    = rd_active;
    assign gop_grant  = s_q.grant;
    assign frame_busy = s_q.busy;
    assign frame_done = s_q.done;

    // R7: while granted, the array is left untouched
    assert_grant_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gop_grant |-> (!read_en && !samp_rst && !samp_sig));

    // R6: a bank is never read and loaded in the same cycle
    assert_bank_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (read_en && (samp_rst || samp_sig)) |-> (read_bank != load_bank));

    // R6: readout never overtakes loading
    assert_read_behind_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rows_rd <= s_q.rows_ld);

    // R5: classic mode never overlaps load and read
    assert_classic_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.zmode) |-> !(read_en && (samp_rst || samp_sig)));

    // R5: classic mode keeps to bank 0
    assert_classic_bank0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.zmode && (samp_rst || samp_sig || read_en)) |->
            (!load_bank && !read_bank));

    // R8: completion is a single-cycle pulse with the frame closed
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!frame_busy && !read_en));

    // R9: the grant never rises without a pending request
    assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gop_grant) |-> $past(s_q.pend));

endmodule

// File: tb/pprs_row_sched_tb.sv
module pprs_row_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 6;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             zero_ovh_mode = 1'b0;
    logic [ROW_W-1:0] row_total = '0;
    logic [CNT_W-1:0] rst_cycles = '0;
    logic [CNT_W-1:0] sig_cycles = '0;
    logic [CNT_W-1:0] read_cycles = '0;
    logic             gop_req = 1'b0;
    logic             gop_done = 1'b0;
    logic             samp_rst, samp_sig, load_bank, read_bank, read_en;
    logic             gop_grant, frame_busy, frame_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    pprs_row_sched #(
        .ROW_W (ROW_W),
        .CNT_W (CNT_W)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .zero_ovh_mode (zero_ovh_mode),
        .row_total     (row_total),
        .rst_cycles    (rst_cycles),
        .sig_cycles    (sig_cycles),
        .read_cycles   (read_cycles),
        .gop_req       (gop_req),
        .gop_done      (gop_done),
        .samp_rst      (samp_rst),
        .samp_sig      (samp_sig),
        .load_bank     (load_bank),
        .read_bank     (read_bank),
        .read_en       (read_en),
        .gop_grant     (gop_grant),
        .frame_busy    (frame_busy),
        .frame_done    (frame_done)
    );

    typedef struct packed {
        logic       z;
        logic [5:0] rows;
        logic [3:0] tr;
        logic [3:0] ts;
        logic [3:0] trd;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 6'd3, 4'd2,  4'd2,  4'd3 },
        '{1'b1, 6'd4, 4'd2,  4'd3,  4'd2 },
        '{1'b1, 6'd4, 4'd1,  4'd1,  4'd6 },
        '{1'b1, 6'd5, 4'd0,  4'd0,  4'd0 },
        '{1'b0, 6'd1, 4'd15, 4'd15, 4'd15},
        '{1'b1, 6'd1, 4'd3,  4'd3,  4'd3 },
        '{1'b1, 6'd6, 4'd2,  4'd2,  4'd4 }
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Per-frame observations
    int r_done_j, c_rst, c_sig, c_rd, c_ld1, c_rd1, c_trans, c_grant, c_viol;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Expected negedge index (counted from the start edge) where frame_done is seen
    function automatic int exp_done(input bit z, input int rows, input int tr,
                                    input int ts, input int trd);
        int l, d, p;
        l = eff(tr) + eff(ts);
        d = eff(trd);
        if (rows == 0) return 1;
        p = z ? ((l > d) ? l : d) + 1 : l + d + 2;
        return l + d + (rows - 1) * p + 3;
    endfunction

    task automatic run_frame(input bit z, input int rows, input int tr, input int ts,
                             input int trd, input int gop_at, input int restart_at);
        int  j;
        bit  prev_rst;
        bit  seen;
        @(negedge clk);
        zero_ovh_mode = z;
        row_total     = ROW_W'(rows);
        rst_cycles    = CNT_W'(tr);
        sig_cycles    = CNT_W'(ts);
        read_cycles   = CNT_W'(trd);
        frame_start   = 1'b1;
        @(posedge clk);
        j = 0; prev_rst = 1'b0; seen = 1'b0;
        c_rst = 0; c_sig = 0; c_rd = 0; c_ld1 = 0; c_rd1 = 0;
        c_trans = 0; c_grant = 0; c_viol = 0; r_done_j = -1;
        while (!seen && j < 4000) begin
            @(negedge clk);
            j++;
            if (samp_rst) c_rst++;
            if (samp_sig) c_sig++;
            if (read_en)  c_rd++;
            if ((samp_rst || samp_sig) && load_bank) c_ld1++;
            if (read_en && read_bank) c_rd1++;
            if (samp_sig && prev_rst) c_trans++;
            prev_rst = samp_rst;
            if (gop_grant) begin
                c_grant++;
                if (samp_rst || samp_sig || read_en) c_viol++;
            end
            if (frame_done) begin
                r_done_j = j;
                seen = 1'b1;
            end
            frame_start = (j == restart_at);
            gop_req     = (j == gop_at);
            gop_done    = gop_grant && (c_grant == 3);
        end
        frame_start = 1'b0;
        gop_req     = 1'b0;
        gop_done    = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_j;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!(samp_rst || samp_sig || read_en || gop_grant || frame_busy || frame_done),
              "R1 reset outputs", int'({samp_rst, samp_sig, read_en, gop_grant, frame_busy, frame_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            int n, tr, ts, trd, l, d;
            n = int'(VECS[v].rows); tr = int'(VECS[v].tr);
            ts = int'(VECS[v].ts); trd = int'(VECS[v].trd);
            l = eff(tr) + eff(ts); d = eff(trd);
            run_frame(VECS[v].z, n, tr, ts, trd, -1, -1);
            exp_j = exp_done(VECS[v].z, n, tr, ts, trd);
            check(r_done_j == exp_j, VECS[v].z ? "R4 frame duration" : "R5 frame duration", r_done_j, exp_j);
            check(c_rst == n * eff(tr), "R2 reset strobe cycles", c_rst, n * eff(tr));
            check(c_sig == n * eff(ts), "R2 signal strobe cycles", c_sig, n * eff(ts));
            check(c_trans == n, "R2 reset-then-signal order", c_trans, n);
            check(c_rd == n * d, "R3 read cycles", c_rd, n * d);
            if (VECS[v].z) begin
                check(c_ld1 == (n / 2) * l, "R4 bank1 load cycles", c_ld1, (n / 2) * l);
                check(c_rd1 == (n / 2) * d, "R4 bank1 read cycles", c_rd1, (n / 2) * d);
            end else begin
                check(c_ld1 == 0 && c_rd1 == 0, "R5 bank0 only", c_ld1 + c_rd1, 0);
            end
            @(negedge clk);
            check(!frame_busy && !frame_done, "R8 done pulse and idle", int'({frame_busy, frame_done}), 0);
        end

        // R6: first readout timing, single row zero mode (L=4, D=2)
        run_frame(1'b1, 1, 2, 2, 2, -1, -1);
        check(r_done_j == 9, "R6 first row load then read", r_done_j, 9);

        // R8: empty frame
        run_frame(1'b1, 0, 3, 3, 3, -1, -1);
        check(r_done_j == 1, "R8 zero-row done", r_done_j, 1);
        check(c_rst + c_sig + c_rd == 0, "R8 zero-row no strobes", c_rst + c_sig + c_rd, 0);

        // R1: second start during a frame is ignored
        run_frame(1'b0, 2, 1, 1, 1, -1, 4);
        exp_j = exp_done(1'b0, 2, 1, 1, 1);
        check(r_done_j == exp_j, "R1 restart ignored duration", r_done_j, exp_j);
        check(c_rd == 2, "R1 restart ignored reads", c_rd, 2);

        // R7: global operation inside a frame
        run_frame(1'b0, 3, 2, 2, 2, 3, -1);
        exp_j = exp_done(1'b0, 3, 2, 2, 2);
        check(c_grant == 3, "R7 grant held until done", c_grant, 3);
        check(c_viol == 0, "R7 quiet during grant", c_viol, 0);
        check(r_done_j > exp_j, "R7 frame stretched", r_done_j, exp_j + 1);
        check(c_rst == 6 && c_sig == 6 && c_rd == 6, "R7 all rows completed", c_rd, 6);

        // R9: done without grant
        @(negedge clk); gop_done = 1'b1;
        @(negedge clk); gop_done = 1'b0;
        @(negedge clk);
        check(!gop_grant, "R9 stray done ignored", gop_grant, 0);

        // R7: request while idle, grant after two edges
        gop_req = 1'b1;
        @(negedge clk); gop_req = 1'b0;
        check(!gop_grant, "R7 grant not yet", gop_grant, 0);
        @(negedge clk);
        check(gop_grant, "R7 grant when idle", gop_grant, 1);
        // R1: start refused while granted
        frame_start = 1'b1; row_total = 6'd2;
        @(negedge clk); frame_start = 1'b0;
        check(!frame_busy && gop_grant, "R1 start refused during grant", frame_busy, 0);
        repeat (3) @(negedge clk);
        check(gop_grant, "R7 grant persists", gop_grant, 1);
        gop_done = 1'b1;
        @(negedge clk); gop_done = 1'b0;
        check(!gop_grant && !frame_busy, "R7 grant released", gop_grant, 0);

        // R7: normal operation afterwards
        run_frame(1'b1, 2, 1, 2, 1, -1, -1);
        exp_j = exp_done(1'b1, 2, 1, 2, 1);
        check(r_done_j == exp_j, "R7 resume after grant", r_done_j, exp_j);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule